// File: doc/BRIEF.md
# Overflow and Match Timer PWM Generator

This block is an up-counting timer that shapes one output line into a PWM wave or a train of pulses. The counter runs from a programmable start value up to all-ones. At the top it wraps back to that start value, so the start value sets the period. An optional compare value marks a point inside the period. A control word chooses which of these two events acts on the line, whether each selected event flips the line or gives a one-clock pulse, the level the line rests at, and whether compare events are produced at all.

Software configures the block through a small synchronous write port with four addresses. It starts and stops the timer with two strobes and watches the overflow and match event outputs. A 50 % wave needs only overflow events, at twice the PWM rate. Any other duty uses overflow and match events, with one overflow per PWM period. Writes that would break the required spacing between the start value, the compare value and the top of the count are refused and flagged. Before starting, the counter may be preloaded with 0xFFFFFFFE so that an overflow comes first.

Top module: `ovm_pwm_timer`

## Requirements
- R1: After reset the output is low, both event outputs are low, the timer is stopped and the error flag is clear.
- R2: While running, the counter advances by one per count tick. At 0xFFFFFFFF it reloads the start value and pulses `ovf_evt` for one clock, so one overflow period is (0xFFFFFFFF - start + 1) ticks.
- R3: Control bits [1:0] select the active events: 0 none, 1 overflow only, 2 or 3 overflow and match. `pwm_out` reacts one clock after the event output pulses.
- R4: With control bit 2 clear (pulse mode), each selected event drives `pwm_out` to the inverse of the idle level for exactly one clock.
- R5: With control bit 2 set (toggle mode), each selected event inverts `pwm_out`. In overflow-only mode the result is a 50 % duty wave with period twice the overflow period.
- R6: `match_evt` pulses when the counter advances by increment onto the compare value, and only when control bit 4 (compare enable) is set. In overflow and match toggle mode the line spends (compare - start) clocks per period in the non-idle level.
- R7: Control bit 3 sets the idle level. The line rests there while stopped, starts from it, and the same event sequence gives the inverted waveform when the bit is set.
- R8: A write of a start value (address 1) or compare value (address 2) above 0xFFFFFFFD is refused, the old value is kept, and `cfg_err` is set. Any accepted write clears `cfg_err`.
- R9: Overflow and match mode requires compare enable and compare >= start + 2. A write to address 0, 1 or 2 that would leave this mode without both conditions met is refused, with `cfg_err` set and the old configuration kept.
- R10: Control bit 8 enables the pre-divider and bits [7:5] give n. The counter then advances once every 2^n clocks, or every clock when bit 8 is clear.
- R11: A `stop` strobe clears `running` and returns `pwm_out` to the idle level on the next clock. The counter then holds and no further events occur. When `stop` and `start` arrive together, `stop` wins.
- R12: A write to address 3 loads the counter directly. Preloading 0xFFFFFFFE gives an overflow on the second count tick after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 start value, 2 compare, 3 counter |
| wr_data | input | 32 | Write data |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe, wins over start |
| pwm_out | output | 1 | Waveform output |
| ovf_evt | output | 1 | One-clock overflow event |
| match_evt | output | 1 | One-clock compare match event |
| running | output | 1 | Timer is running |
| cfg_err | output | 1 | Last write was refused |

## Verification
The hardest situation to reach is a wrap of a 32-bit count, which would take billions of clocks from an ordinary start value. The stimulus preloads the counter with 0xFFFFFFFE and sets start values a few counts below all-ones, so every period is 16 ticks and overflow, match and their relative timing can be measured between event pulses. The spacing rules are reached by changing the start, compare and mode values in different orders. Each order probes one side of the rule, and the kept configuration is then observed in the measured waveform.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int PRE_W = 3;

    typedef enum logic [1:0] {
        TRIG_NONE     = 2'd0,
        TRIG_OVF      = 2'd1,
        TRIG_BOTH     = 2'd2,
        TRIG_BOTH_ALT = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_LOAD = 2'd1,
        ADDR_CMP  = 2'd2,
        ADDR_CNT  = 2'd3
    } addr_e;

    typedef struct packed {
        logic             pre_en;
        logic [PRE_W-1:0] pre_exp;
        logic             cmp_en;
        logic             idle_hi;
        logic             toggle;
        trig_e            trig;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic uses_match(trig_e t);
        return (t == TRIG_BOTH) || (t == TRIG_BOTH_ALT);
    endfunction

endpackage

// File: rtl/pwmt_cfg_regs.sv
module pwmt_cfg_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             err_o,
    output logic             cnt_wr_o,
    output logic [CNT_W-1:0] cnt_wdata_o
);

    localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}} - CNT_W'(2);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cmp;
        logic             err;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    function automatic logic spaced(logic [CNT_W-1:0] lo, logic [CNT_W-1:0] hi);
        return {1'b0, hi} >= ({1'b0, lo} + (CNT_W+1)'(2));
    endfunction

    always_comb begin
        ctrl_t new_ctrl;
        logic  ok;
        cfg_d    = cfg_q;
        new_ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
        ok       = 1'b1;
        if (wr_en_i) begin
            unique case (addr_e'(wr_addr_i))
                ADDR_CTRL: begin
                    ok = !uses_match(new_ctrl.trig)
                         || (new_ctrl.cmp_en && spaced(cfg_q.load, cfg_q.cmp));
                    if (ok) cfg_d.ctrl = new_ctrl;
                end
                ADDR_LOAD: begin
                    ok = (wr_data_i <= LIMIT)
                         && (!uses_match(cfg_q.ctrl.trig) || spaced(wr_data_i, cfg_q.cmp));
                    if (ok) cfg_d.load = wr_data_i;
                end
                ADDR_CMP: begin
                    ok = (wr_data_i <= LIMIT)
                         && (!uses_match(cfg_q.ctrl.trig) || spaced(cfg_q.load, wr_data_i));
                    if (ok) cfg_d.cmp = wr_data_i;
                end
                default: ok = 1'b1;
            endcase
            cfg_d.err = !ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl_o      = cfg_q.ctrl;
    assign load_o      = cfg_q.load;
    assign cmp_o       = cfg_q.cmp;
    assign err_o       = cfg_q.err;
    assign cnt_wr_o    = wr_en_i && (addr_e'(wr_addr_i) == ADDR_CNT);
    assign cnt_wdata_o = wr_data_i;

    assert_load_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o <= LIMIT) && (cmp_o <= LIMIT));

    assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uses_match(ctrl_o.trig) |-> (ctrl_o.cmp_en && ({1'b0, cmp_o} >= {1'b0, load_o} + (CNT_W+1)'(2))));

endmodule

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             en_i,
    input  logic [PRE_W-1:0] exp_i,
    output logic             tick_o
);

    localparam int DIV_W = (1 << PRE_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_s;

    pre_s pre_d, pre_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = ~({DIV_W{1'b1}} << exp_i);
        tick_o = run_i && (!en_i || (pre_q.div == mask));
        pre_d  = pre_q;
        if (!run_i || tick_o) pre_d.div = '0;
        else                  pre_d.div = pre_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && (exp_i != '0)) |=> (!tick_o || !en_i || (exp_i == '0)));

endmodule

// File: rtl/pwmt_count_core.sv
module pwmt_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             cmp_en_i,
    output logic             running_o,
    output logic             ovf_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             match;
    } core_s;

    core_s core_d, core_q;

    always_comb begin
        core_d       = core_q;
        core_d.ovf   = 1'b0;
        core_d.match = 1'b0;
        if (stop_i)       core_d.run = 1'b0;
        else if (start_i) core_d.run = 1'b1;
        if (cnt_wr_i) begin
            core_d.cnt = cnt_wdata_i;
        end else if (core_q.run && tick_i) begin
            if (core_q.cnt == TOP) begin
                core_d.cnt = load_i;
                core_d.ovf = 1'b1;
            end else begin
                core_d.cnt   = core_q.cnt + ONE;
                core_d.match = cmp_en_i && ((core_q.cnt + ONE) == cmp_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign running_o = core_q.run;
    assign ovf_o     = core_q.ovf;
    assign match_o   = core_q.match;

    assert_wrap_from_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(core_q.cnt) == TOP));

    assert_match_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(cmp_en_i) && (core_q.cnt == $past(cmp_i))));

    assert_no_event_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && match_o));

endmodule

// File: rtl/pwmt_wave_out.sv
module pwmt_wave_out
    import pwmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  halt_i,
    input  logic  ovf_i,
    input  logic  match_i,
    input  trig_e trig_i,
    input  logic  toggle_i,
    input  logic  idle_hi_i,
    output logic  pwm_o
);

    typedef struct packed {
        logic level;
        logic pulse;
    } wave_s;

    wave_s wave_d, wave_q;
    logic  sel;

    always_comb begin
        sel    = (ovf_i && (trig_i != TRIG_NONE)) || (match_i && uses_match(trig_i));
        wave_d = wave_q;
        if (halt_i) begin
            wave_d.level = idle_hi_i;
            wave_d.pulse = 1'b0;
        end else begin
            if (sel && toggle_i) wave_d.level = ~wave_q.level;
            wave_d.pulse = sel && !toggle_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= '0;
        else        wave_q <= wave_d;
    end

    assign pwm_o = toggle_i ? wave_q.level : (idle_hi_i ^ wave_q.pulse);

    assert_idle_after_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt_i) && $past(toggle_i) && toggle_i) |-> (pwm_o == $past(idle_hi_i)));

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_i && (pwm_o != idle_hi_i) && $stable(idle_hi_i)) |=> (!$stable(toggle_i) || !$stable(idle_hi_i) || (pwm_o == idle_hi_i) || $past(sel)));

endmodule

// File: rtl/ovm_pwm_timer.sv
module ovm_pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             start,
    input  logic             stop,
    output logic             pwm_out,
    output logic             ovf_evt,
    output logic             match_evt,
    output logic             running,
    output logic             cfg_err
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cmp_val;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic             tick;

    pwmt_cfg_regs #(.CNT_W(CNT_W)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ctrl_o      (ctrl),
        .load_o      (load_val),
        .cmp_o       (cmp_val),
        .err_o       (cfg_err),
        .cnt_wr_o    (cnt_wr),
        .cnt_wdata_o (cnt_wdata)
    );

    pwmt_prescaler i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .en_i   (ctrl.pre_en),
        .exp_i  (ctrl.pre_exp),
        .tick_o (tick)
    );

    pwmt_count_core #(.CNT_W(CNT_W)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .stop_i      (stop),
        .tick_i      (tick),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (cnt_wdata),
        .load_i      (load_val),
        .cmp_i       (cmp_val),
        .cmp_en_i    (ctrl.cmp_en),
        .running_o   (running),
        .ovf_o       (ovf_evt),
        .match_o     (match_evt)
    );

    pwmt_wave_out i_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (stop || !running),
        .ovf_i     (ovf_evt),
        .match_i   (match_evt),
        .trig_i    (ctrl.trig),
        .toggle_i  (ctrl.toggle),
        .idle_hi_i (ctrl.idle_hi),
        .pwm_o     (pwm_out)
    );

    assert_stopped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(running) && !running) |-> (!ovf_evt && !match_evt));

endmodule

// File: tb/test_ovm_pwm_timer.sv
module test_ovm_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        pwm_out, ovf_evt, match_evt, running, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [31:0] LD  = 32'hFFFF_FFF0;
    localparam logic [31:0] CMP = 32'hFFFF_FFFA;
    localparam logic [31:0] PRE = 32'hFFFF_FFFE;

    always #4 clk = ~clk;

    ovm_pwm_timer i_ovm_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .stop(stop), .pwm_out(pwm_out), .ovf_evt(ovf_evt),
        .match_evt(match_evt), .running(running), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int trig, input bit tgl, input bit idle,
                                       input bit ce, input bit pre_en, input int pexp);
        return {23'd0, pre_en, 3'(pexp), ce, idle, tgl, 2'(trig)};
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic setup(input logic [31:0] ctrl, input logic [31:0] ld, input logic [31:0] cmp);
        do_stop();
        wr(0, 32'd0);
        wr(1, ld);
        wr(2, cmp);
        wr(3, PRE);
        wr(0, ctrl);
        do_start();
    endtask

    task automatic wait_evt(input bit use_match, output int cycles);
        cycles = -1;
        for (int i = 1; i <= 5000; i++) begin
            @(negedge clk);
            if ((use_match ? match_evt : ovf_evt) === 1'b1) begin
                cycles = i;
                break;
            end
        end
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) highs++;
        end
    endtask

    task automatic count_evt(input bit use_match, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((use_match ? match_evt : ovf_evt) === 1'b1) cnt++;
        end
    endtask

    task automatic t_reset();
        check(pwm_out === 1'b0, "R1 pwm", pwm_out, 0);
        check(ovf_evt === 1'b0 && match_evt === 1'b0, "R1 events", ovf_evt | match_evt, 0);
        check(running === 1'b0, "R1 running", running, 0);
        check(cfg_err === 1'b0, "R1 err", cfg_err, 0);
    endtask

    task automatic t_first_ovf();
        wr(1, LD);
        wr(3, PRE);
        wr(0, cw(1, 1, 0, 0, 0, 0));
        do_start();
        check(running === 1'b1, "R11 running after start", running, 1);
        @(negedge clk);
        check(ovf_evt === 1'b0, "R12 no ovf on first tick", ovf_evt, 0);
        @(negedge clk);
        check(ovf_evt === 1'b1, "R12 ovf on second tick", ovf_evt, 1);
        check(pwm_out === 1'b0, "R3 pwm not yet changed", pwm_out, 0);
        @(negedge clk);
        check(pwm_out === 1'b1, "R3 pwm one clock after ovf", pwm_out, 1);
    endtask

    task automatic t_period_half();
        int gap, highs;
        wait_evt(0, gap);
        wait_evt(0, gap);
        check(gap == 16, "R2 overflow period", gap, 16);
        count_high(64, highs);
        check(highs == 32, "R5 half duty", highs, 32);
    endtask

    task automatic t_prescale();
        int gap;
        setup(cw(1, 1, 0, 0, 1, 2), LD, CMP);
        wait_evt(0, gap);
        wait_evt(0, gap);
        check(gap == 64, "R10 divide by 4", gap, 64);
        setup(cw(1, 1, 0, 0, 0, 2), LD, CMP);
        wait_evt(0, gap);
        wait_evt(0, gap);
        check(gap == 16, "R10 bypass", gap, 16);
    endtask

    task automatic t_none();
        int highs, n;
        setup(cw(0, 1, 0, 0, 0, 0), LD, CMP);
        fork
            count_high(48, highs);
            count_evt(0, 48, n);
        join
        check(highs == 0, "R3 trig none keeps idle", highs, 0);
        check(n == 3, "R3 ovf still counted", n, 3);
    endtask

    task automatic t_pulse();
        int highs;
        setup(cw(1, 0, 0, 0, 0, 0), LD, CMP);
        count_high(64, highs);
        check(highs == 4, "R4 pulse idle low", highs, 4);
        setup(cw(1, 0, 1, 0, 0, 0), LD, CMP);
        count_high(64, highs);
        check(highs == 60, "R4 pulse idle high", highs, 60);
    endtask

    task automatic t_match();
        int gap, highs;
        setup(cw(2, 1, 0, 1, 0, 0), LD, CMP);
        wait_evt(0, gap);
        wait_evt(1, gap);
        check(gap == 10, "R6 ovf to match", gap, 10);
        wait_evt(0, gap);
        check(gap == 6, "R6 match to ovf", gap, 6);
        count_high(64, highs);
        check(highs == 40, "R6 duty from compare", highs, 40);
        setup(cw(2, 1, 1, 1, 0, 0), LD, CMP);
        @(negedge clk);
        check(pwm_out === 1'b1, "R7 starts at idle high", pwm_out, 1);
        wait_evt(0, gap);
        count_high(64, highs);
        check(highs == 24, "R7 inverted phase", highs, 24);
    endtask

    task automatic t_cmp_enable();
        int n;
        setup(cw(1, 1, 0, 0, 0, 0), LD, CMP);
        count_evt(1, 48, n);
        check(n == 0, "R6 no match without enable", n, 0);
        setup(cw(1, 1, 0, 1, 0, 0), LD, CMP);
        count_evt(1, 48, n);
        check(n == 3, "R6 match with enable", n, 3);
    endtask

    task automatic t_limits();
        int gap;
        setup(cw(1, 1, 0, 0, 0, 0), LD, CMP);
        wr(1, 32'hFFFF_FFFE);
        check(cfg_err === 1'b1, "R8 load over limit", cfg_err, 1);
        wait_evt(0, gap);
        wait_evt(0, gap);
        check(gap == 16, "R8 old load kept", gap, 16);
        wr(2, 32'hFFFF_FFFF);
        check(cfg_err === 1'b1, "R8 compare over limit", cfg_err, 1);
        wr(2, 32'hFFFF_FFFD);
        check(cfg_err === 1'b0, "R8 limit value accepted", cfg_err, 0);
    endtask

    task automatic t_spacing();
        int highs;
        setup(cw(1, 1, 0, 0, 0, 0), LD, CMP);
        wr(0, cw(2, 1, 0, 0, 0, 0));
        check(cfg_err === 1'b1, "R9 both mode needs enable", cfg_err, 1);
        count_high(64, highs);
        check(highs == 32, "R9 old mode kept", highs, 32);
        wr(2, LD + 32'd1);
        check(cfg_err === 1'b0, "R9 close compare ok in ovf mode", cfg_err, 0);
        wr(0, cw(2, 1, 0, 1, 0, 0));
        check(cfg_err === 1'b1, "R9 mode refused for spacing 1", cfg_err, 1);
        wr(2, LD + 32'd2);
        wr(0, cw(2, 1, 0, 1, 0, 0));
        check(cfg_err === 1'b0, "R9 spacing 2 accepted", cfg_err, 0);
        wr(1, LD + 32'd1);
        check(cfg_err === 1'b1, "R9 load write refused", cfg_err, 1);
    endtask

    task automatic t_stop();
        int n;
        setup(cw(1, 1, 0, 0, 0, 0), LD, CMP);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) break;
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(pwm_out === 1'b0, "R11 idle next clock", pwm_out, 0);
        check(running === 1'b0, "R11 stopped", running, 0);
        count_evt(0, 40, n);
        check(n == 0, "R11 no events while stopped", n, 0);
        @(negedge clk);
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check(running === 1'b0, "R11 stop wins", running, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_first_ovf();
        t_period_half();
        t_prescale();
        t_none();
        t_pulse();
        t_match();
        t_cmp_enable();
        t_limits();
        t_spacing();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule